// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block sits after a timer's waveform generator. It takes one waveform bit and drives a pair of outputs. One output follows the waveform and the other is its complement.

When the timer runs a PWM mode with the complementary output setting, the block delays every rising edge on either output by a programmable number of prescaled clock cycles. Because of this delay the two outputs are never high together. The non-inverted output takes its delay from the high nibble of an 8-bit dead-time value and the inverted output from the low nibble. The dead-time count advances on a tick that divides the clock by 1, 2, 4 or 8.

In every other configuration the block is a one-clock synchronizer for the non-inverted output. The block also chooses, for each pin, between the generator output and the general port value, and it passes the pin's direction bit through as the output enable.

The controller has five states:
- `ST_SYNC`: synchronizer; also the reset state.
- `ST_LOW`: steady, with non-inverted low and inverted high.
- `ST_HIGH`: steady, with non-inverted high and inverted low.
- `ST_WAIT_P`: both outputs low while the non-inverted rise is pending.
- `ST_WAIT_N`: both outputs low while the inverted rise is pending.

The transitions are:
- Leaving complementary operation sends any state to `ST_SYNC`.
- Entering complementary operation moves `ST_SYNC` to `ST_HIGH` or `ST_LOW`, following the waveform.
- A rising waveform in `ST_LOW` or `ST_WAIT_N` goes to `ST_WAIT_P`, which loads the counter and restarts the prescaler. If the non-inverted field is 0 it goes straight to `ST_HIGH`.
- A falling waveform in `ST_HIGH` or `ST_WAIT_P` goes to `ST_WAIT_N`. If the inverted field is 0 it goes straight to `ST_LOW`.
- `ST_WAIT_P` moves to `ST_HIGH`, and `ST_WAIT_N` moves to `ST_LOW`, on the tick that ends the count.

Top module: `cpwm_deadtime_gen`

## Requirements
- R1: During and after reset, before any clock samples a high waveform, both generator outputs `gen_p_o` and `gen_n_o` are 0.
- R2: Complementary operation is active only when `mode_i` is 01 (fast PWM) or 10 (phase-and-frequency-correct PWM) and `com_i` is 01. Modes 00 (normal) and 11 (reserved) never enable it.
- R3: Outside complementary operation, `gen_p_o` equals the waveform bit sampled at the previous clock edge, and `gen_n_o` is held at 0.
- R4: In complementary operation, a rising waveform drives `gen_n_o` low at the first clock edge that samples it high. `gen_p_o` rises `dt_val_i[7:4]` × div clock edges later.
- R5: In complementary operation, a falling waveform drives `gen_p_o` low at the first clock edge that samples it low. `gen_n_o` rises `dt_val_i[3:0]` × div clock edges later.
- R6: `presc_i` values 00, 01, 10 and 11 give div = 1, 2, 4 and 8. The prescaler restarts at each waveform edge, so every delay is an exact multiple of div.
- R7: A dead-time field of 0 makes the pending output rise at the same edge at which the other output falls.
- R8: A waveform toggle during a pending dead time cancels the pending rise and starts the count for the new edge.
- R9: The dead-time field is captured when the edge is detected. Changing `dt_val_i` during the count has no effect on that count.
- R10: When either bit of `com_i` is set, each pin value (`pin_p_o`, `pin_n_o`) is the matching generator output. Otherwise it is the matching port value (`port_p_i`, `port_n_i`).
- R11: Each pin's output enable equals that pin's direction bit (1 = output).
- R12: `gen_p_o` and `gen_n_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_i | input | 1 | Waveform bit from the compare unit |
| mode_i | input | 2 | Timer mode: 00 normal, 01 fast PWM, 10 phase/frequency correct, 11 reserved |
| com_i | input | 2 | Compare-output-mode field |
| dt_val_i | input | 8 | [7:4] non-inverted dead time, [3:0] inverted dead time |
| presc_i | input | 2 | Dead-time prescaler select |
| port_p_i | input | 1 | General port value for the non-inverted pin |
| port_n_i | input | 1 | General port value for the inverted pin |
| dir_p_i | input | 1 | Direction bit, non-inverted pin |
| dir_n_i | input | 1 | Direction bit, inverted pin |
| gen_p_o | output | 1 | Non-inverted generator output |
| gen_n_o | output | 1 | Inverted generator output |
| pin_p_o | output | 1 | Non-inverted pin value |
| pin_n_o | output | 1 | Inverted pin value |
| pin_p_oe | output | 1 | Non-inverted pin output enable |
| pin_n_oe | output | 1 | Inverted pin output enable |

## Verification
The hardest situation to reach is a waveform edge that arrives while the opposite dead time is still counting. It requires a toggle inside the window of a pending rise, which is narrow at small field values. The bench sets a long delay on the pending output and toggles the waveform a known number of cycles after the first edge. It then measures the rise of the other output and watches for any overlap.

A second case is a field change in the middle of a count. The bench rewrites `dt_val_i` one cycle after the edge is detected.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic [2:0] {
        ST_SYNC,
        ST_LOW,
        ST_HIGH,
        ST_WAIT_P,
        ST_WAIT_N
    } dt_state_e;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_FAST   = 2'b01;
    localparam logic [1:0] MODE_PFC    = 2'b10;
    localparam logic [1:0] COM_COMPL   = 2'b01;
endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask   = CNT_W'((32'd1 << sel_i) - 32'd1);
        tick_o = ((cnt & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt <= '0;
        else                 cnt <= cnt + CNT_W'(1);
    end

    // R6: a divided tick is never followed by another tick unless the ratio changed
    a_r6_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != '0 && tick_o) |=> (!tick_o || !$stable(sel_i)));
endmodule

// File: rtl/dt_fsm.sv
module dt_fsm
    import cpwm_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wave_i,
    input  logic            comp_i,
    input  logic [DT_W-1:0] dly_p_i,
    input  logic [DT_W-1:0] dly_n_i,
    input  logic            tick_i,
    output logic            clr_o,
    output logic            gen_p_o,
    output logic            gen_n_o
);
    dt_state_e       st, st_nxt;
    logic [DT_W-1:0] cnt, cnt_nxt;
    logic            wave_q;
    logic            load;

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        load    = 1'b0;
        if (!comp_i) begin
            st_nxt = ST_SYNC;
        end else begin
            unique case (st)
                ST_SYNC: st_nxt = wave_i ? ST_HIGH : ST_LOW;
                ST_LOW, ST_WAIT_N: begin
                    if (wave_i) begin
                        if (dly_p_i == '0) st_nxt = ST_HIGH;
                        else begin
                            st_nxt  = ST_WAIT_P;
                            cnt_nxt = dly_p_i;
                            load    = 1'b1;
                        end
                    end else if (st == ST_WAIT_N && tick_i) begin
                        if (cnt == DT_W'(1)) st_nxt = ST_LOW;
                        else                 cnt_nxt = cnt - DT_W'(1);
                    end
                end
                ST_HIGH, ST_WAIT_P: begin
                    if (!wave_i) begin
                        if (dly_n_i == '0) st_nxt = ST_LOW;
                        else begin
                            st_nxt  = ST_WAIT_N;
                            cnt_nxt = dly_n_i;
                            load    = 1'b1;
                        end
                    end else if (st == ST_WAIT_P && tick_i) begin
                        if (cnt == DT_W'(1)) st_nxt = ST_HIGH;
                        else                 cnt_nxt = cnt - DT_W'(1);
                    end
                end
                default: st_nxt = ST_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_SYNC;
            cnt    <= '0;
            wave_q <= 1'b0;
        end else begin
            st     <= st_nxt;
            cnt    <= cnt_nxt;
            wave_q <= wave_i;
        end
    end

    always_comb begin
        clr_o = load;
        unique case (st)
            ST_SYNC: begin gen_p_o = wave_q; gen_n_o = 1'b0; end
            ST_LOW:  begin gen_p_o = 1'b0;   gen_n_o = 1'b1; end
            ST_HIGH: begin gen_p_o = 1'b1;   gen_n_o = 1'b0; end
            default: begin gen_p_o = 1'b0;   gen_n_o = 1'b0; end
        endcase
    end

    // R12: the pair never overlaps
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_p_o && gen_n_o));
    // R3: synchronizer behaviour outside complementary operation
    a_r3_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!comp_i && $past(!comp_i) && $past(rst_n)) |-> (gen_p_o == $past(wave_i) && !gen_n_o));
    // R4: the non-inverted output rises only after a high waveform sample
    a_r4_p_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_p_o) |-> $past(wave_i));
    // R5: the inverted output rises only after a low waveform sample
    a_r5_n_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_n_o) |-> !$past(wave_i));
endmodule

// File: rtl/cpwm_pin_mux.sv
module cpwm_pin_mux (
    input  logic [1:0] com_i,
    input  logic       gen_p_i,
    input  logic       gen_n_i,
    input  logic       port_p_i,
    input  logic       port_n_i,
    input  logic       dir_p_i,
    input  logic       dir_n_i,
    output logic       pin_p_o,
    output logic       pin_n_o,
    output logic       pin_p_oe,
    output logic       pin_n_oe
);
    logic take_over;

    always_comb begin
        take_over = |com_i;
        pin_p_o   = take_over ? gen_p_i : port_p_i;
        pin_n_o   = take_over ? gen_n_i : port_n_i;
        pin_p_oe  = dir_p_i;
        pin_n_oe  = dir_n_i;
    end
endmodule

// File: rtl/cpwm_deadtime_gen.sv
module cpwm_deadtime_gen
    import cpwm_pkg::*;
#(
    parameter int DT_W  = 4,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wave_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        com_i,
    input  logic [2*DT_W-1:0] dt_val_i,
    input  logic [SEL_W-1:0]  presc_i,
    input  logic              port_p_i,
    input  logic              port_n_i,
    input  logic              dir_p_i,
    input  logic              dir_n_i,
    output logic              gen_p_o,
    output logic              gen_n_o,
    output logic              pin_p_o,
    output logic              pin_n_o,
    output logic              pin_p_oe,
    output logic              pin_n_oe
);
    logic comp;
    logic tick;
    logic clr;

    assign comp = ((mode_i == MODE_FAST) || (mode_i == MODE_PFC)) && (com_i == COM_COMPL);

    dt_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .sel_i  (presc_i),
        .tick_o (tick)
    );

    dt_fsm #(.DT_W(DT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wave_i  (wave_i),
        .comp_i  (comp),
        .dly_p_i (dt_val_i[2*DT_W-1:DT_W]),
        .dly_n_i (dt_val_i[DT_W-1:0]),
        .tick_i  (tick),
        .clr_o   (clr),
        .gen_p_o (gen_p_o),
        .gen_n_o (gen_n_o)
    );

    cpwm_pin_mux u_pins (
        .com_i    (com_i),
        .gen_p_i  (gen_p_o),
        .gen_n_i  (gen_n_o),
        .port_p_i (port_p_i),
        .port_n_i (port_n_i),
        .dir_p_i  (dir_p_i),
        .dir_n_i  (dir_n_i),
        .pin_p_o  (pin_p_o),
        .pin_n_o  (pin_n_o),
        .pin_p_oe (pin_p_oe),
        .pin_n_oe (pin_n_oe)
    );
endmodule

// File: tb/tb_cpwm_deadtime_gen.sv
module tb_cpwm_deadtime_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wave_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [1:0] com_i = 2'b00;
    logic [7:0] dt_val_i = 8'h00;
    logic [1:0] presc_i = 2'b00;
    logic       port_p_i = 1'b0, port_n_i = 1'b0, dir_p_i = 1'b0, dir_n_i = 1'b0;
    logic       gen_p_o, gen_n_o, pin_p_o, pin_n_o, pin_p_oe, pin_n_oe;

    int n_checks = 0;
    int n_fail = 0;
    int overlap_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpwm_deadtime_gen dut (
        .clk(clk), .rst_n(rst_n), .wave_i(wave_i), .mode_i(mode_i), .com_i(com_i),
        .dt_val_i(dt_val_i), .presc_i(presc_i), .port_p_i(port_p_i), .port_n_i(port_n_i),
        .dir_p_i(dir_p_i), .dir_n_i(dir_n_i), .gen_p_o(gen_p_o), .gen_n_o(gen_n_o),
        .pin_p_o(pin_p_o), .pin_n_o(pin_n_o), .pin_p_oe(pin_p_oe), .pin_n_oe(pin_n_oe)
    );

    always @(negedge clk) if (rst_n && gen_p_o && gen_n_o) overlap_seen++;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Drive the waveform to lvl and count edges until the watched output goes high.
    task automatic edge_to_rise(input logic lvl, input bit watch_p, output int cycles, output logic other_first);
        wave_i = lvl;
        cycles = 0;
        other_first = 1'b1;
        for (int i = 0; i < 300; i++) begin
            step(1);
            cycles++;
            if (cycles == 1) other_first = watch_p ? gen_n_o : gen_p_o;
            if (watch_p ? gen_p_o : gen_n_o) break;
        end
    endtask

    task automatic enter_comp(input logic [7:0] dt, input logic [1:0] ps);
        mode_i = 2'b01; com_i = 2'b01; dt_val_i = dt; presc_i = ps; wave_i = 1'b0;
        step(3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wave_i = 1'b1;
        step(2);
        check("R1 gen_p in reset", gen_p_o, 0);
        check("R1 gen_n in reset", gen_n_o, 0);
        wave_i = 1'b0;
        step(1);
        rst_n = 1'b1;
        step(1);
        check("R1 gen_p after reset", gen_p_o, 0);
        check("R1 gen_n after reset", gen_n_o, 0);
    endtask

    task automatic t_sync();
        mode_i = 2'b00; com_i = 2'b01;
        wave_i = 1'b1;
        #3;
        check("R3 no change before edge", gen_p_o, 0);
        step(1);
        check("R3 follows after one edge", gen_p_o, 1);
        check("R3 inverted held low", gen_n_o, 0);
        wave_i = 1'b0; step(1);
        check("R3 follows low", gen_p_o, 0);
        mode_i = 2'b11; com_i = 2'b01; wave_i = 1'b1; step(2);
        check("R2 reserved mode no pair", gen_n_o, 0);
        check("R2 reserved mode sync", gen_p_o, 1);
        mode_i = 2'b01; com_i = 2'b10; wave_i = 1'b0; step(2);
        check("R2 com=10 inverted low", gen_n_o, 0);
        check("R2 com=10 sync", gen_p_o, 0);
    endtask

    task automatic t_basic_delays();
        int c; logic o;
        enter_comp(8'h35, 2'b00);
        check("R2 fast PWM com=01 steady inverted high", gen_n_o, 1);
        edge_to_rise(1'b1, 1'b1, c, o);
        check("R4 inverted falls at first edge", o, 0);
        check("R4 rise delay div1 k=3", c, 4);
        edge_to_rise(1'b0, 1'b0, c, o);
        check("R5 non-inverted falls at first edge", o, 0);
        check("R5 rise delay div1 k=5", c, 6);
        mode_i = 2'b10;
        step(2);
        check("R2 phase/freq mode steady low", gen_n_o, 1);
    endtask

    task automatic t_prescale();
        int c; logic o;
        enter_comp(8'h35, 2'b01);
        edge_to_rise(1'b1, 1'b1, c, o);
        check("R6 div2 k=3", c, 7);
        presc_i = 2'b10; step(1);
        edge_to_rise(1'b0, 1'b0, c, o);
        check("R6 div4 k=5", c, 21);
        presc_i = 2'b11; dt_val_i = 8'h25; step(1);
        edge_to_rise(1'b1, 1'b1, c, o);
        check("R6 div8 k=2", c, 17);
    endtask

    task automatic t_zero();
        int c; logic o;
        enter_comp(8'h00, 2'b11);
        edge_to_rise(1'b1, 1'b1, c, o);
        check("R7 zero rise same edge", c, 1);
        check("R7 inverted low", o, 0);
        edge_to_rise(1'b0, 1'b0, c, o);
        check("R7 zero fall same edge", c, 1);
    endtask

    task automatic t_cancel();
        int c; logic o; int p_hi;
        enter_comp(8'h93, 2'b00);
        wave_i = 1'b1;
        p_hi = 0;
        for (int i = 0; i < 3; i++) begin step(1); p_hi += int'(gen_p_o); end
        edge_to_rise(1'b0, 1'b0, c, o);
        check("R8 pending rise cancelled", p_hi + int'(o), 0);
        check("R8 new count restarts", c, 4);
        check("R12 no overlap seen", overlap_seen, 0);
    endtask

    task automatic t_field_capture();
        int c; logic o;
        enter_comp(8'h31, 2'b00);
        wave_i = 1'b1;
        step(1);
        dt_val_i = 8'h91;
        c = 1;
        for (int i = 0; i < 40; i++) begin
            step(1); c++;
            if (gen_p_o) break;
        end
        check("R9 captured field used", c, 4);
    endtask

    task automatic t_pins();
        mode_i = 2'b00; com_i = 2'b00; wave_i = 1'b1;
        port_p_i = 1'b0; port_n_i = 1'b1; dir_p_i = 1'b1; dir_n_i = 1'b0;
        step(2);
        check("R10 port value on p pin", pin_p_o, 0);
        check("R10 port value on n pin", pin_n_o, 1);
        check("R11 p enable", pin_p_oe, 1);
        check("R11 n enable", pin_n_oe, 0);
        com_i = 2'b10; step(1);
        check("R10 generator on p pin", pin_p_o, 1);
        check("R10 generator on n pin", pin_n_o, 0);
        dir_p_i = 1'b0; dir_n_i = 1'b1; #1;
        check("R11 p enable off", pin_p_oe, 0);
        check("R11 n enable on", pin_n_oe, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_sync();
        t_basic_delays();
        t_prescale();
        t_zero();
        t_cancel();
        t_field_capture();
        t_pins();
        check("R12 no overlap overall", overlap_seen, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule